// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire serial link to a delta-sigma converter: an active-low select, a serial clock that the host drives, and a data line that the converter drives. When `start` pulses, the reader pulls select low. The converter shows its conversion-busy flag on the data line at once, with no clock. The reader samples that flag on every system clock, and the serial clock stays idle while it waits. When the flag reads low, the reader issues exactly 32 serial clock pulses and captures one data bit on each rising edge, most significant bit first. It then releases select.

The captured word is split into fields. The sign sits in bit 29. The 24-bit result sits in bits 28 to 5. Five bits below the result resolution sit in bits 4 to 0 and are passed out on their own, so the consumer can keep or drop them. Input out of range is flagged from the sign bit and the result's top bit. A high dummy bit or a high busy bit in the captured word marks the frame as corrupt. If the busy flag never clears, a programmable limit ends the wait and raises an error pulse.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, and `res_valid` and `timeout_err` are low.
- R2: After `start` in idle, `cs_n` goes low. `sclk` stays low while `sdo` samples high (converter busy). No serial clock pulse is issued until `sdo` samples low.
- R3: Once `sdo` samples low, exactly 32 rising `sclk` edges follow. `sdo` is captured on each rising edge, first bit as bit 31. `cs_n` rises with the final falling edge.
- R4: Each `sclk` low phase and each high phase lasts `div_half`+1 system clock cycles, so one read spends 32*(`div_half`+1) cycles with `sclk` high.
- R5: `res_sign` equals captured bit 29, `res_mag` equals bits 28..5 (bit 5 as its LSB), and `res_sub` equals bits 4..0.
- R6: `res_over` is high when bits 29 and 28 are both 1. `res_under` is high when both are 0. The two are never high together.
- R7: `res_frame_err` is high when captured bit 30 or bit 31 is 1.
- R8: In the wait, `sdo` may sample high on `timeout_lim` consecutive cycles and the read still proceeds. On the next high sample, the reader returns `cs_n` high, issues no clock, and pulses `timeout_err` for one cycle instead of `res_valid`.
- R9: `res_valid` is a one-cycle pulse, given with `cs_n` already high after the 32nd bit. `sclk` is never high while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one read (acted on only when idle) |
| div_half | input | DIV_W | Serial clock half period minus one, in system cycles |
| timeout_lim | input | TO_W | Busy samples tolerated before abort |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | One-cycle strobe: decoded fields are valid |
| res_sign | output | 1 | Sign bit of the result |
| res_mag | output | 24 | 24-bit conversion result |
| res_sub | output | 5 | Bits below the result resolution |
| res_over | output | 1 | Input at or above positive full scale |
| res_under | output | 1 | Input below negative full scale |
| res_frame_err | output | 1 | Dummy or busy bit found high in the frame |
| timeout_err | output | 1 | One-cycle strobe: busy flag never cleared |

## Verification
The wait-limit abort and the end-of-busy detection can fall on the same sample, because both are decided from one `sdo` sample in the same cycle. The bench's converter model holds the busy flag for a set number of samples, and the case is provoked by setting that number equal to `timeout_lim`. On the last allowed sample the timer is at its limit and the flag reads low on that same sample. The read must then complete with a correct frame and no error pulse. With one more busy sample, the bench must see only `timeout_err` and zero clock pulses.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int FRAME_W = 32;
  localparam int RES_W   = 24;
  localparam int SUB_W   = 5;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);
  localparam int BIT_BSY = FRAME_W - 1;
  localparam int BIT_DMY = FRAME_W - 2;
  localparam int BIT_SGN = FRAME_W - 3;
  localparam int BIT_TOP = FRAME_W - 4;

  typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_SHIFT} rd_state_e;

  typedef struct packed {
    logic             sign;
    logic [RES_W-1:0] mag;
    logic [SUB_W-1:0] sub;
    logic             over;
    logic             under;
    logic             frame_err;
  } afr_fields_t;
endpackage

// File: rtl/afr_tick.sv
module afr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div_half);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sdo,
  input  logic               tick,
  input  logic [TO_W-1:0]    timeout_lim,
  output logic               run,
  output logic               cs_n,
  output logic               sclk,
  output logic [FRAME_W-1:0] frame,
  output logic               done,
  output logic               to_err
);
  rd_state_e          st_q, st_d;
  logic               cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic [TO_W-1:0]    timer_q, timer_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               done_q, done_d, toerr_q, toerr_d;

  always_comb begin
    st_d    = st_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    bcnt_d  = bcnt_q;
    timer_d = timer_q;
    frame_d = frame_q;
    done_d  = 1'b0;
    toerr_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_POLL;
          cs_n_d  = 1'b0;
          timer_d = '0;
        end
      end
      ST_POLL: begin
        if (!sdo) begin
          st_d   = ST_SHIFT;
          bcnt_d = '0;
        end else if (timer_q >= timeout_lim) begin
          st_d    = ST_IDLE;
          cs_n_d  = 1'b1;
          toerr_d = 1'b1;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d  = 1'b1;
            frame_d = {frame_q[FRAME_W-2:0], sdo};
            bcnt_d  = bcnt_q + 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bcnt_q == BCNT_W'(FRAME_W)) begin
              st_d   = ST_IDLE;
              cs_n_d = 1'b1;
              done_d = 1'b1;
            end
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        cs_n_d = 1'b1;
        sclk_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      bcnt_q  <= '0;
      timer_q <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
      toerr_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      bcnt_q  <= bcnt_d;
      timer_q <= timer_d;
      frame_q <= frame_d;
      done_q  <= done_d;
      toerr_q <= toerr_d;
    end
  end

  assign run    = (st_q == ST_SHIFT);
  assign cs_n   = cs_n_q;
  assign sclk   = sclk_q;
  assign frame  = frame_q;
  assign done   = done_q;
  assign to_err = toerr_q;

  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q);
  // R2
  poll_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POLL) |-> !sclk_q);
  // R3
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BCNT_W'(FRAME_W));
  // R8
  abort_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toerr_q |-> (cs_n_q && !done_q));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/afr_decode.sv
module afr_decode
  import afr_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output afr_fields_t        fields
);
  always_comb begin
    fields.sign      = frame[BIT_SGN];
    fields.mag       = frame[BIT_TOP -: RES_W];
    fields.sub       = frame[SUB_W-1:0];
    fields.over      = frame[BIT_SGN] & frame[BIT_TOP];
    fields.under     = ~frame[BIT_SGN] & ~frame[BIT_TOP];
    fields.frame_err = frame[BIT_DMY] | frame[BIT_BSY];
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div_half,
  input  logic [TO_W-1:0]  timeout_lim,
  input  logic             sdo,
  output logic             cs_n,
  output logic             sclk,
  output logic             res_valid,
  output logic             res_sign,
  output logic [23:0]      res_mag,
  output logic [4:0]       res_sub,
  output logic             res_over,
  output logic             res_under,
  output logic             res_frame_err,
  output logic             timeout_err
);
  logic               run, tick, done;
  logic [FRAME_W-1:0] frame;
  afr_fields_t        dec, fields_q;
  logic               valid_q;

  afr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div_half(div_half), .tick(tick)
  );

  afr_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo), .tick(tick),
    .timeout_lim(timeout_lim), .run(run), .cs_n(cs_n), .sclk(sclk),
    .frame(frame), .done(done), .to_err(timeout_err)
  );

  afr_decode u_dec (.frame(frame), .fields(dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      fields_q <= '0;
    end else begin
      valid_q <= done;
      if (done) fields_q <= dec;
    end
  end

  assign res_valid     = valid_q;
  assign res_sign      = fields_q.sign;
  assign res_mag       = fields_q.mag;
  assign res_sub       = fields_q.sub;
  assign res_over      = fields_q.over;
  assign res_under     = fields_q.under;
  assign res_frame_err = fields_q.frame_err;

  // R6
  range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_over && res_under));
  // R9
  valid_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && !sclk));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20;

  typedef struct {
    bit          is_to;
    bit          sign;
    logic [23:0] mag;
    logic [4:0]  sub;
    bit          over;
    bit          under;
    bit          ferr;
    int          div;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  div_half = 8'd0;
  logic [15:0] timeout_lim = 16'(LIMIT);
  logic        sdo;
  logic        cs_n, sclk, res_valid, res_sign, res_over, res_under;
  logic        res_frame_err, timeout_err;
  logic [23:0] res_mag;
  logic [4:0]  res_sub;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  logic [31:0] frame_m = '0;
  int          busy_cfg = 0;
  int          busy_m = 0;
  logic [4:0]  idx = 5'd31;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half),
    .timeout_lim(timeout_lim), .sdo(sdo), .cs_n(cs_n), .sclk(sclk),
    .res_valid(res_valid), .res_sign(res_sign), .res_mag(res_mag),
    .res_sub(res_sub), .res_over(res_over), .res_under(res_under),
    .res_frame_err(res_frame_err), .timeout_err(timeout_err)
  );

  // converter model: busy flag counts down per cycle while selected
  always @(posedge clk) begin
    if (cs_n) busy_m <= busy_cfg;
    else if (busy_m > 0) busy_m <= busy_m - 1;
  end

  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) idx <= 5'd31;
    else      idx <= idx - 5'd1;
  end

  assign sdo = cs_n ? 1'b1 : ((idx == 5'd31) ? (busy_m != 0) : frame_m[idx]);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input bit dmy, input bit sgn,
                                     input logic [23:0] mag, input logic [4:0] sub);
    return {1'b0, dmy, sgn, mag, sub};
  endfunction

  task automatic run_read(input logic [31:0] fr, input int busy, input int div,
                          input bit expect_to);
    exp_t e;
    while (!cs_n) @(negedge clk);
    e.is_to = expect_to;
    e.sign  = fr[29];
    e.mag   = fr[28:5];
    e.sub   = fr[4:0];
    e.over  = fr[29] & fr[28];
    e.under = !fr[29] & !fr[28];
    e.ferr  = fr[30] | fr[31];
    e.div   = div;
    frame_m  = fr;
    busy_cfg = busy;
    div_half = 8'(div);
    q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  int rises = 0;
  int high_cyc = 0;
  logic sclk_prev = 1'b0;
  logic valid_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_prev) rises++;
      if (sclk) high_cyc++;
      sclk_prev = sclk;
      if (valid_prev) check(!res_valid, "R9", "valid width", res_valid, 0);
      valid_prev = res_valid;
      if (res_valid || timeout_err) begin
        if (q.size() == 0) begin
          check(0, "R8", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.is_to) begin
            check(timeout_err && !res_valid, "R8", "abort kind", timeout_err, 1);
            check(rises == 0, "R2", "clock pulses while busy", rises, 0);
            check(cs_n, "R8", "select released", cs_n, 1);
          end else begin
            check(res_valid && !timeout_err, "R8", "completion kind", res_valid, 1);
            check(res_sign == e.sign, "R5", "sign", res_sign, e.sign);
            check(res_mag == e.mag, "R5", "magnitude", res_mag, e.mag);
            check(res_sub == e.sub, "R5", "sub bits", res_sub, e.sub);
            check(res_over == e.over, "R6", "over", res_over, e.over);
            check(res_under == e.under, "R6", "under", res_under, e.under);
            check(res_frame_err == e.ferr, "R7", "frame error", res_frame_err, e.ferr);
            check(rises == 32, "R3", "pulse count", rises, 32);
            check(high_cyc == 32 * (e.div + 1), "R4", "high cycles",
                  high_cyc, 32 * (e.div + 1));
            check(cs_n && !sclk, "R9", "idle at strobe", {cs_n, sclk}, 2'b10);
          end
        end
        rises = 0;
        high_cyc = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    check(!res_valid && !timeout_err, "R1", "strobes in reset",
          {res_valid, timeout_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);

    run_read(mk(0, 1, 24'h123456, 5'h15), 5, 0, 0);        // R5 positive
    run_read(mk(0, 0, 24'h800001, 5'h0A), 3, 3, 0);        // R4 slower clock
    run_read(mk(0, 1, 24'hC00000, 5'h1F), 0, 1, 0);        // R6 overrange
    run_read(mk(0, 0, 24'h3FFFFF, 5'h00), 7, 2, 0);        // R6 underrange
    run_read(mk(1, 1, 24'h0F0F0F, 5'h11), 2, 0, 0);        // R7 dummy high
    run_read(mk(0, 1, 24'h7A5A5A, 5'h03), LIMIT, 1, 0);    // R8 last allowed sample
    run_read(mk(0, 1, 24'h000001, 5'h01), LIMIT + 1, 0, 1); // R8 abort
    run_read(mk(0, 1, 24'h000001, 5'h01), 1000, 0, 1);     // R2 long busy
    run_read(mk(0, 0, 24'hFFFFFF, 5'h10), 4, 5, 0);        // R3 after abort

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule